// File: doc/BRIEF.md
# Multi-Policy Register Field Bank

A compact memory-mapped register bank in which every register carries one field whose software access behaviour is fixed at elaboration. Ten behaviours are available: plain storage, hardware-owned read-only, write-only with a constant read-back, write-once locking, three status-clearing styles (clear where 1 is written, clear where 0 is written, clear on read), set-only, write-triggered event and toggle. Bits of a word above the field are reserved.

Software reaches the bank through a simple synchronous bus with a word address, write enable, write data, byte strobes, read enable and read data. Read data is registered and appears in the cycle after the read request. Hardware logic uses a side port. It loads read-only and event fields directly and raises status bits, and it receives every field's stored value plus a one-cycle pulse for each write to an event field.

Top module: `regbank`

## Requirements
- R1: After reset each field holds its elaboration reset value, every event pulse is low and read data is 0.
- R2: A plain field takes written data in the bytes whose strobe is 1 (strobe bit k covers data bits 8k+7..8k) and returns the stored value on the next-cycle read.
- R3: A read-only field ignores bus writes and loads the hardware value whenever its hardware load enable is 1.
- R4: A write-only field stores strobed writes (visible on the hardware value output), but a bus read always returns its reset value.
- R5: A write-once field accepts only the first write since reset whose strobes cover any field byte; later writes leave it unchanged.
- R6: A clear-on-1 field clears the bits written as 1 under an active strobe, keeps bits written as 0, and a hardware set of a bit in the same cycle as its clear leaves the bit at 1.
- R7: A clear-on-0 field clears the bits written as 0 under an active strobe, keeps bits written as 1 or under an inactive strobe, and a same-cycle hardware set wins.
- R8: A clear-on-read field returns its value and then becomes 0; writes have no effect; a hardware set in the same cycle as the read survives and is returned by the next read.
- R9: A set-only field sets the bits written as 1 and never clears a bit from the bus.
- R10: Any write to an event field, whatever its data or strobes, raises that field's pulse for exactly the cycle after the write; the stored value changes only through the hardware load.
- R11: A toggle field inverts the bits written as 1 under an active strobe; bits written as 0 keep their value.
- R12: Reserved bits above the field always read 0; a write to an address beyond the last register changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr_en | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_strb | input | DATA_W/8 | Byte strobes for writes |
| bus_rd_en | input | 1 | Read request |
| bus_rdata | output | DATA_W | Registered read data |
| hw_we | input | NUM_REGS | Per-register hardware load enable (read-only and event fields) |
| hw_wdata | input | NUM_REGS*FIELD_W | Hardware load values, register i at bits i*FIELD_W upward |
| hw_set | input | NUM_REGS*FIELD_W | Hardware bit sets for the three status styles |
| field_q | output | NUM_REGS*FIELD_W | Stored value of every field |
| trig_pulse | output | NUM_REGS | One-cycle event pulses |

## Verification
Two actions can meet on one status bit in a single cycle: a hardware set and a software clear. The clear comes from a bus write on the two clear-on-write styles, or from a bus read on the clear-on-read style. The bench drives the bus request and the hardware set on the same falling edge for each of the three styles. It then reads the field back and expects the hardware-set bits to remain 1 while the other targeted bits clear. For the clear-on-read case, the colliding read must still return the value from before the set, and only the following read shows the set bit.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [3:0] {
    ACC_RW   = 4'd0,
    ACC_RO   = 4'd1,
    ACC_WO   = 4'd2,
    ACC_ONCE = 4'd3,
    ACC_W1C  = 4'd4,
    ACC_W0C  = 4'd5,
    ACC_RC   = 4'd6,
    ACC_W1S  = 4'd7,
    ACC_TRIG = 4'd8,
    ACC_TOG  = 4'd9
  } access_e;

  // Fields whose bits hardware may raise
  function automatic bit is_status(access_e a);
    return (a == ACC_W1C) || (a == ACC_W0C) || (a == ACC_RC);
  endfunction

  // Fields whose whole value hardware may load
  function automatic bit is_hw_loaded(access_e a);
    return (a == ACC_RO) || (a == ACC_TRIG);
  endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [DATA_W/8-1:0] strb,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [DATA_W-1:0]   bit_mask
);
  localparam int STRB_W = DATA_W / 8;

  function automatic logic [DATA_W-1:0] expand_strobes(logic [STRB_W-1:0] s);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < STRB_W; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction

  assign bit_mask = expand_strobes(strb);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (addr == ADDR_W'(i));
    assign rd_sel[i] = rd_en && (addr == ADDR_W'(i));
  end

  // R12
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(addr) >= NUM_REGS)) |-> (wr_sel == '0));

endmodule

// File: rtl/rb_field.sv
module rb_field
  import regbank_pkg::*;
#(
  parameter int               FIELD_W = 16,
  parameter access_e          POLICY  = ACC_RW,
  parameter logic [FIELD_W-1:0] RST   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic               rd_sel,
  input  logic [FIELD_W-1:0] wdata,
  input  logic [FIELD_W-1:0] wmask,
  input  logic               hw_we,
  input  logic [FIELD_W-1:0] hw_wdata,
  input  logic [FIELD_W-1:0] hw_set,
  output logic [FIELD_W-1:0] val_o,
  output logic [FIELD_W-1:0] view_o,
  output logic               trig_o
);

  function automatic logic [FIELD_W-1:0] merge_bits(
      logic [FIELD_W-1:0] old_v, logic [FIELD_W-1:0] new_v, logic [FIELD_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [FIELD_W-1:0] clear_then_set(
      logic [FIELD_W-1:0] old_v, logic [FIELD_W-1:0] clr, logic [FIELD_W-1:0] setv);
    return (old_v & ~clr) | setv;
  endfunction

  logic [FIELD_W-1:0] val_q, val_d;
  logic [FIELD_W-1:0] ones_wr;   // bits written as 1 under active strobe
  logic [FIELD_W-1:0] zeros_wr;  // bits written as 0 under active strobe
  logic [FIELD_W-1:0] hw_or;
  logic               lock_q, lock_d;
  logic               sw_touch;
  logic               trig_q;

  assign sw_touch = wr_sel && (wmask != '0);
  assign ones_wr  = wr_sel ? (wdata & wmask) : '0;
  assign zeros_wr = wr_sel ? (~wdata & wmask) : '0;
  assign hw_or    = is_status(POLICY) ? hw_set : '0;

  always_comb begin
    val_d  = val_q;
    lock_d = lock_q;
    unique case (POLICY)
      ACC_RW, ACC_WO: if (wr_sel) val_d = merge_bits(val_q, wdata, wmask);
      ACC_RO, ACC_TRIG: if (hw_we) val_d = hw_wdata;
      ACC_ONCE: if (sw_touch && !lock_q) begin
        val_d  = merge_bits(val_q, wdata, wmask);
        lock_d = 1'b1;
      end
      ACC_W1C: val_d = clear_then_set(val_q, ones_wr, hw_or);
      ACC_W0C: val_d = clear_then_set(val_q, zeros_wr, hw_or);
      ACC_RC:  val_d = clear_then_set(val_q, {FIELD_W{rd_sel}}, hw_or);
      ACC_W1S: val_d = val_q | ones_wr;
      ACC_TOG: val_d = val_q ^ ones_wr;
      default: val_d = val_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= RST;
      lock_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      lock_q <= lock_d;
      trig_q <= (POLICY == ACC_TRIG) && wr_sel;
    end
  end

  assign val_o  = val_q;
  assign view_o = (POLICY == ACC_WO) ? RST : val_q;
  assign trig_o = trig_q;

  if (POLICY == ACC_RO) begin : g_ro_chk
    // R3
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_we |=> $stable(val_q));
  end

  if (POLICY == ACC_ONCE) begin : g_once_chk
    // R5
    once_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(val_q));
  end

  if (is_status(POLICY)) begin : g_status_chk
    // R6
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((val_q & $past(hw_set)) == $past(hw_set)));
  end

  if (POLICY == ACC_RC) begin : g_rc_chk
    // R8
    rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && hw_set == '0) |=> (val_q == '0));
  end

  if (POLICY == ACC_W1S) begin : g_w1s_chk
    // R9
    w1s_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((val_q & $past(val_q)) == $past(val_q)));
  end

  if (POLICY == ACC_TRIG) begin : g_trig_chk
    // R10
    trig_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> trig_o);
    // R10
    trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> !trig_o);
  end

  if (POLICY == ACC_TOG) begin : g_tog_chk
    // R11
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sel || (wdata & wmask) == '0) |=> $stable(val_q));
  end

endmodule

// File: rtl/rb_readmux.sv
module rb_readmux #(
  parameter int NUM_REGS = 10,
  parameter int FIELD_W  = 16,
  parameter int DATA_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [NUM_REGS-1:0]           rd_sel,
  input  logic [NUM_REGS*FIELD_W-1:0]   views,
  output logic [DATA_W-1:0]             rd_data
);
  logic [FIELD_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel[i]) picked = picked | views[i*FIELD_W +: FIELD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= DATA_W'(picked);
  end

  // R12
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == '0) |=> (rd_data == '0));

  // R12
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((rd_data >> FIELD_W) == '0));

endmodule

// File: rtl/regbank.sv
module regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 16,
  parameter int NUM_REGS = 10,
  parameter access_e POLICY [NUM_REGS] = '{ACC_RW, ACC_RO, ACC_WO, ACC_ONCE, ACC_W1C,
                                          ACC_W0C, ACC_RC, ACC_W1S, ACC_TRIG, ACC_TOG},
  parameter logic [FIELD_W-1:0] RST_VAL [NUM_REGS] = '{16'h00A5, 16'h1234, 16'h5A5A,
                                          16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                          16'h0000, 16'h00C3, 16'h000F}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr_en,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic [DATA_W/8-1:0]         bus_strb,
  input  logic                        bus_rd_en,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_REGS-1:0]         hw_we,
  input  logic [NUM_REGS*FIELD_W-1:0] hw_wdata,
  input  logic [NUM_REGS*FIELD_W-1:0] hw_set,
  output logic [NUM_REGS*FIELD_W-1:0] field_q,
  output logic [NUM_REGS-1:0]         trig_pulse
);
  localparam int STRB_W = DATA_W / 8;

  logic [NUM_REGS-1:0]         wr_sel;
  logic [NUM_REGS-1:0]         rd_sel;
  logic [DATA_W-1:0]           bit_mask;
  logic [NUM_REGS*FIELD_W-1:0] views;
  logic                        rsvd_unused;

  // reserved write bits are decoded but never stored
  assign rsvd_unused = ^{bus_wdata, bit_mask};

  rb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .strb(bus_strb[STRB_W-1:0]), .wr_sel(wr_sel), .rd_sel(rd_sel), .bit_mask(bit_mask)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
    rb_field #(
      .FIELD_W(FIELD_W), .POLICY(POLICY[i]), .RST(RST_VAL[i])
    ) u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_sel[i]),
      .rd_sel  (rd_sel[i]),
      .wdata   (bus_wdata[FIELD_W-1:0]),
      .wmask   (bit_mask[FIELD_W-1:0]),
      .hw_we   (hw_we[i]),
      .hw_wdata(hw_wdata[i*FIELD_W +: FIELD_W]),
      .hw_set  (hw_set[i*FIELD_W +: FIELD_W]),
      .val_o   (field_q[i*FIELD_W +: FIELD_W]),
      .view_o  (views[i*FIELD_W +: FIELD_W]),
      .trig_o  (trig_pulse[i])
    );
  end

  rb_readmux #(
    .NUM_REGS(NUM_REGS), .FIELD_W(FIELD_W), .DATA_W(DATA_W)
  ) u_readmux (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .rd_sel(rd_sel),
    .views(views), .rd_data(bus_rdata)
  );

endmodule

// File: tb/tb_regbank.sv
module tb_regbank;
  localparam int FW = 16;
  localparam int NR = 10;
  localparam int A_RW = 0, A_RO = 1, A_WO = 2, A_ONCE = 3, A_W1C = 4;
  localparam int A_W0C = 5, A_RC = 6, A_W1S = 7, A_TRIG = 8, A_TOG = 9, A_OOB = 12;
  localparam logic [FW-1:0] EXP_RST [NR] = '{16'h00A5, 16'h1234, 16'h5A5A, 16'h0000,
      16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00C3, 16'h000F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_strb = '0;
  logic [31:0] bus_rdata;
  logic [NR-1:0] hw_we = '0;
  logic [NR*FW-1:0] hw_wdata = '0, hw_set = '0;
  logic [NR*FW-1:0] field_q;
  logic [NR-1:0] trig_pulse;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rd_en(bus_rd_en),
    .bus_rdata(bus_rdata), .hw_we(hw_we), .hw_wdata(hw_wdata), .hw_set(hw_set),
    .field_q(field_q), .trig_pulse(trig_pulse)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_strb = s; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic hw_pulse(input int i, input logic [FW-1:0] setv);
    @(negedge clk);
    hw_set[i*FW +: FW] = setv;
    @(negedge clk);
    hw_set = '0;
  endtask

  task automatic hw_load(input int i, input logic [FW-1:0] v);
    @(negedge clk);
    hw_we[i] = 1'b1; hw_wdata[i*FW +: FW] = v;
    @(negedge clk);
    hw_we = '0;
  endtask

  task automatic t_reset();
    chk("R1", "rdata after reset", bus_rdata, 32'h0);
    chk("R1", "pulses after reset", 32'(trig_pulse), 32'h0);
    for (int i = 0; i < NR; i++)
      chk("R1", $sformatf("field %0d reset", i), 32'(field_q[i*FW +: FW]), 32'(EXP_RST[i]));
  endtask

  task automatic t_rw();
    logic [31:0] d;
    wr(A_RW, 32'hFFFF_BEEF, 4'b0001);
    wr(A_RW, 32'h0000_1200, 4'b0010);
    rd(A_RW, d); chk("R2", "byte-strobed writes", d, 32'h0000_12EF);
    wr(A_RW, 32'hFFFF_FFFF, 4'b1111);
    rd(A_RW, d); chk("R12", "reserved bits read 0", d, 32'h0000_FFFF);
    wr(A_OOB, 32'h0000_0000, 4'b1111);
    rd(A_OOB, d); chk("R12", "out-of-range read", d, 32'h0);
    rd(A_RW, d); chk("R12", "out-of-range write harmless", d, 32'h0000_FFFF);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(A_RO, 32'h0000_FFFF, 4'b1111);
    rd(A_RO, d); chk("R3", "bus write ignored", d, 32'h0000_1234);
    hw_load(A_RO, 16'h7777);
    rd(A_RO, d); chk("R3", "hardware load", d, 32'h0000_7777);
  endtask

  task automatic t_wo();
    logic [31:0] d;
    wr(A_WO, 32'h0000_1111, 4'b0011);
    chk("R4", "stored value", 32'(field_q[A_WO*FW +: FW]), 32'h1111);
    rd(A_WO, d); chk("R4", "read returns reset", d, 32'h0000_5A5A);
  endtask

  task automatic t_once();
    logic [31:0] d;
    wr(A_ONCE, 32'h0000_0000, 4'b0000);
    wr(A_ONCE, 32'h0000_0042, 4'b0001);
    rd(A_ONCE, d); chk("R5", "first write", d, 32'h0000_0042);
    wr(A_ONCE, 32'h0000_0099, 4'b0011);
    rd(A_ONCE, d); chk("R5", "second write ignored", d, 32'h0000_0042);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    hw_pulse(A_W1C, 16'h00FF);
    rd(A_W1C, d); chk("R6", "hardware set", d, 32'h0000_00FF);
    wr(A_W1C, 32'h0000_000F, 4'b0011);
    rd(A_W1C, d); chk("R6", "clear on 1", d, 32'h0000_00F0);
    wr(A_W1C, 32'h0000_0000, 4'b0011);
    rd(A_W1C, d); chk("R6", "write 0 no effect", d, 32'h0000_00F0);
    @(negedge clk);
    bus_addr = 4'(A_W1C); bus_wdata = 32'h0000_00F0; bus_strb = 4'b0011; bus_wr_en = 1'b1;
    hw_set[A_W1C*FW +: FW] = 16'h0010;
    @(negedge clk);
    bus_wr_en = 1'b0; hw_set = '0;
    rd(A_W1C, d); chk("R6", "hw set wins collision", d, 32'h0000_0010);
  endtask

  task automatic t_w0c();
    logic [31:0] d;
    hw_pulse(A_W0C, 16'h00FF);
    wr(A_W0C, 32'h0000_FFF0, 4'b0011);
    rd(A_W0C, d); chk("R7", "clear on 0", d, 32'h0000_00F0);
    wr(A_W0C, 32'h0000_FFFF, 4'b0011);
    rd(A_W0C, d); chk("R7", "write 1 no effect", d, 32'h0000_00F0);
    wr(A_W0C, 32'h0000_0000, 4'b0000);
    rd(A_W0C, d); chk("R7", "inactive strobes", d, 32'h0000_00F0);
    @(negedge clk);
    bus_addr = 4'(A_W0C); bus_wdata = 32'h0; bus_strb = 4'b0011; bus_wr_en = 1'b1;
    hw_set[A_W0C*FW +: FW] = 16'h0080;
    @(negedge clk);
    bus_wr_en = 1'b0; hw_set = '0;
    rd(A_W0C, d); chk("R7", "hw set wins collision", d, 32'h0000_0080);
  endtask

  task automatic t_rc();
    logic [31:0] d;
    hw_pulse(A_RC, 16'h0003);
    wr(A_RC, 32'h0, 4'b1111);
    rd(A_RC, d); chk("R8", "read returns value", d, 32'h0000_0003);
    rd(A_RC, d); chk("R8", "cleared after read", d, 32'h0);
    @(negedge clk);
    bus_addr = 4'(A_RC); bus_rd_en = 1'b1;
    hw_set[A_RC*FW +: FW] = 16'h0004;
    @(negedge clk);
    bus_rd_en = 1'b0; hw_set = '0;
    chk("R8", "colliding read returns old", bus_rdata, 32'h0);
    rd(A_RC, d); chk("R8", "hw set survives read", d, 32'h0000_0004);
  endtask

  task automatic t_w1s();
    logic [31:0] d;
    wr(A_W1S, 32'h0000_0005, 4'b0001);
    wr(A_W1S, 32'h0000_0002, 4'b0001);
    rd(A_W1S, d); chk("R9", "set accumulates", d, 32'h0000_0007);
    wr(A_W1S, 32'h0000_0000, 4'b0011);
    rd(A_W1S, d); chk("R9", "write 0 no clear", d, 32'h0000_0007);
  endtask

  task automatic t_trig();
    logic [31:0] d;
    chk("R10", "idle pulse", 32'(trig_pulse[A_TRIG]), 32'h0);
    wr(A_TRIG, 32'h0000_FFFF, 4'b0011);
    chk("R10", "pulse after write", 32'(trig_pulse[A_TRIG]), 32'h1);
    @(negedge clk);
    chk("R10", "pulse one cycle", 32'(trig_pulse[A_TRIG]), 32'h0);
    rd(A_TRIG, d); chk("R10", "value kept", d, 32'h0000_00C3);
    wr(A_TRIG, 32'h0, 4'b0000);
    chk("R10", "pulse with no strobes", 32'(trig_pulse[A_TRIG]), 32'h1);
    hw_load(A_TRIG, 16'h0055);
    rd(A_TRIG, d); chk("R10", "hardware load", d, 32'h0000_0055);
  endtask

  task automatic t_tog();
    logic [31:0] d;
    wr(A_TOG, 32'h0000_00FF, 4'b0011);
    rd(A_TOG, d); chk("R11", "toggle", d, 32'h0000_00F0);
    wr(A_TOG, 32'h0000_0000, 4'b0011);
    rd(A_TOG, d); chk("R11", "write 0 no effect", d, 32'h0000_00F0);
    wr(A_TOG, 32'h0000_FFFF, 4'b0001);
    rd(A_TOG, d); chk("R11", "strobed toggle", d, 32'h0000_000F);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rw();
    t_ro();
    t_wo();
    t_once();
    t_w1c();
    t_w0c();
    t_rc();
    t_w1s();
    t_trig();
    t_tog();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule